// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits next to a direct-mapped cache and keeps the lines that the cache most recently threw out. Whenever the direct-mapped array displaces a line, the line (its line address, its data and its modified flag) is handed to this buffer. When the direct-mapped array misses, the same line address is presented to the lookup port. Every entry compares its stored line address in the same cycle, and a hit returns the data and the modified flag straight away.

A hit hands the line back to the direct-mapped array. If the array displaces a line in that same cycle, the displaced line is written into the entry that just hit, so the two lines trade places. A lookup that misses raises a fetch request toward the next memory level. A displaced line arriving with no hit goes into a free entry if one exists. Otherwise it overwrites the entry named by a rotating replacement pointer. If that overwritten line is modified, it is sent out on the writeback port one cycle later.

Top module: `victim_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and the writeback output `wb_valid` is low.
- R2: A lookup compares the full line address against all entries in the same cycle. On a hit, `lkp_hit`, `lkp_data` and `lkp_dirty` show the matching entry's contents combinationally.
- R3: A lookup that misses drives `fetch_req` high and `fetch_addr` equal to `lkp_addr` in the same cycle. A lookup that hits never raises `fetch_req`.
- R4: A lookup hit with no eviction in the same cycle invalidates the matching entry. A later lookup of that address misses.
- R5: A lookup hit with an eviction in the same cycle writes the evicted line into the matching entry and produces no writeback. After it, the old address misses and the evicted address hits with the new data and modified flag.
- R6: An eviction with no lookup hit goes into the lowest-numbered invalid entry while any entry is invalid. It leaves every valid entry intact and produces no writeback.
- R7: When all 4 entries are valid, an eviction with no lookup hit overwrites the entry at the replacement pointer. The pointer starts at entry 0 after reset and advances by one, modulo 4, after each such overwrite only.
- R8: An overwritten entry whose modified flag is set is presented one cycle later on `wb_valid`, `wb_addr` and `wb_data` for exactly one cycle. A clean overwritten entry is dropped without any writeback.
- R9: While `lkp_valid` is low, `lkp_hit` and `fetch_req` stay low and the stored lines are unchanged. While `evict_valid` is low, nothing is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | A displaced line is offered this cycle |
| evict_addr | input | ADDR_W | Line address of the displaced line |
| evict_data | input | LINE_W | Data of the displaced line |
| evict_dirty | input | 1 | Displaced line is modified |
| lkp_valid | input | 1 | Lookup request (direct-mapped array missed) |
| lkp_addr | input | ADDR_W | Line address looked up |
| lkp_hit | output | 1 | Lookup found the line |
| lkp_data | output | LINE_W | Data of the found line |
| lkp_dirty | output | 1 | Found line is modified |
| fetch_req | output | 1 | Lookup missed; fetch from the lower level |
| fetch_addr | output | ADDR_W | Line address to fetch |
| wb_valid | output | 1 | A modified line is being written back |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
The bench first fills the buffer so that the first overwritten line is modified and the second is clean. A design that wrote back clean lines, or lost modified ones, shows up here as a spurious or missing `wb_valid`. It then frees one entry with a consuming hit and checks that the next eviction goes into that hole while the pointer holds its place. A design that advanced the pointer on every insertion would later overwrite the wrong line. It also checks that a swap keeps the entry count, writes nothing back, and makes the old address miss. A design that inserted the evicted line as a separate entry would push out an unrelated line instead.

// File: rtl/vc_pkg.sv
package vc_pkg;
    // Classification of what one cycle does to the buffer
    typedef enum logic [2:0] {
        VC_IDLE,     // nothing stored changes
        VC_TAKE,     // hit, line leaves the buffer
        VC_SWAP,     // hit and displaced line trade places
        VC_FILL,     // displaced line enters a free entry
        VC_REPLACE   // displaced line overwrites the pointed entry
    } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int N      = 4,
    parameter int ADDR_W = 26,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      valid,
    input  logic [ADDR_W-1:0] tags [N],
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [N-1:0] match;

    // one comparator per entry, all evaluated together
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end
    assign hit = |match;

    // a line address lives in at most one entry
    AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2
endmodule

// File: rtl/vc_slot_sel.sv
module vc_slot_sel #(
    parameter int N      = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] ptr,
    output logic             free_any,
    output logic [IDX_W-1:0] slot
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end
    assign free_any = ~&valid;
    assign slot     = free_any ? free_idx : ptr;
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int N      = 4,
    parameter int ADDR_W = 26,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              evict_dirty,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_hit,
    output logic [LINE_W-1:0] lkp_data,
    output logic              lkp_dirty,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    import vc_pkg::*;

    localparam int IDX_W = $clog2(N);
    localparam int CNT_W = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]     valid;
        logic [N-1:0]     dirty;
        logic [IDX_W-1:0] ptr;
        logic             wb_valid;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] tag_d [N];
    logic [ADDR_W-1:0] tag_q [N];
    logic [LINE_W-1:0] data_d [N];
    logic [LINE_W-1:0] data_q [N];
    logic [ADDR_W-1:0] wb_addr_d, wb_addr_q;
    logic [LINE_W-1:0] wb_data_d, wb_data_q;

    logic             match_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             free_any;
    logic [IDX_W-1:0] slot;
    vc_op_e           op;

    vc_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (ctrl_q.valid),
        .tags    (tag_q),
        .addr    (lkp_addr),
        .hit     (match_hit),
        .hit_idx (hit_idx)
    );

    vc_slot_sel #(.N(N)) u_sel (
        .valid    (ctrl_q.valid),
        .ptr      (ctrl_q.ptr),
        .free_any (free_any),
        .slot     (slot)
    );

    always_comb begin
        if (lkp_valid && match_hit)
            op = evict_valid ? VC_SWAP : VC_TAKE;
        else if (evict_valid)
            op = free_any ? VC_FILL : VC_REPLACE;
        else
            op = VC_IDLE;

        ctrl_d          = ctrl_q;
        ctrl_d.wb_valid = 1'b0;
        tag_d           = tag_q;
        data_d          = data_q;
        wb_addr_d       = wb_addr_q;
        wb_data_d       = wb_data_q;

        unique case (op)
            VC_TAKE: ctrl_d.valid[hit_idx] = 1'b0;
            VC_SWAP: begin
                tag_d[hit_idx]        = evict_addr;
                data_d[hit_idx]       = evict_data;
                ctrl_d.dirty[hit_idx] = evict_dirty;
            end
            VC_FILL: begin
                tag_d[slot]        = evict_addr;
                data_d[slot]       = evict_data;
                ctrl_d.dirty[slot] = evict_dirty;
                ctrl_d.valid[slot] = 1'b1;
            end
            VC_REPLACE: begin
                if (ctrl_q.dirty[slot]) begin
                    ctrl_d.wb_valid = 1'b1;
                    wb_addr_d       = tag_q[slot];
                    wb_data_d       = data_q[slot];
                end
                tag_d[slot]        = evict_addr;
                data_d[slot]       = evict_data;
                ctrl_d.dirty[slot] = evict_dirty;
                ctrl_d.ptr = (ctrl_q.ptr == IDX_W'(N - 1)) ? '0 : ctrl_q.ptr + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_ff @(posedge clk) begin
        tag_q     <= tag_d;
        data_q    <= data_d;
        wb_addr_q <= wb_addr_d;
        wb_data_q <= wb_data_d;
    end

    assign lkp_hit    = lkp_valid && match_hit;
    assign lkp_data   = data_q[hit_idx];
    assign lkp_dirty  = lkp_hit && ctrl_q.dirty[hit_idx];
    assign fetch_req  = lkp_valid && !match_hit;
    assign fetch_addr = lkp_addr;
    assign wb_valid   = ctrl_q.wb_valid;
    assign wb_addr    = wb_addr_q;
    assign wb_data    = wb_data_q;

    logic [CNT_W-1:0] n_valid;
    assign n_valid = CNT_W'($countones(ctrl_q.valid));

    AST_NO_FETCH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> !fetch_req); // R3
    AST_TAKE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_hit && !evict_valid) |=> n_valid == $past(n_valid) - 1'b1); // R4
    AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_hit && evict_valid) |=> (n_valid == $past(n_valid)) && !wb_valid); // R5
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !lkp_hit && n_valid < CNT_W'(N))
        |=> (n_valid == $past(n_valid) + 1'b1) && !wb_valid); // R6
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !lkp_hit && n_valid == CNT_W'(N)) |=> n_valid == CNT_W'(N)); // R7
    AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(evict_valid) && $past(n_valid) == CNT_W'(N)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lkp_valid && !evict_valid) |=> $stable(ctrl_q.valid)); // R9
endmodule

// File: tb/victim_cache_test.sv
module victim_cache_test;
    localparam int ADDR_W = 26;
    localparam int LINE_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evict_valid = 1'b0;
    logic [ADDR_W-1:0] evict_addr = '0;
    logic [LINE_W-1:0] evict_data = '0;
    logic              evict_dirty = 1'b0;
    logic              lkp_valid = 1'b0;
    logic [ADDR_W-1:0] lkp_addr = '0;
    logic              lkp_hit, lkp_dirty, fetch_req, wb_valid;
    logic [LINE_W-1:0] lkp_data, wb_data;
    logic [ADDR_W-1:0] fetch_addr, wb_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    victim_cache #(.N(4), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_dirty(evict_dirty),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .lkp_hit(lkp_hit), .lkp_data(lkp_data), .lkp_dirty(lkp_dirty),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic logic [ADDR_W-1:0] la(int i);
        return ADDR_W'(32'h0040_0000 + i * 32'h0000_1040);
    endfunction
    function automatic logic [LINE_W-1:0] ld(int i);
        return {32'(i) * 32'h0101_0101, ~32'(i)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // offer a displaced line; check the writeback output one cycle later
    task automatic evict(int i, bit dirty, bit exp_wb, int wb_i, string req);
        @(negedge clk);
        evict_valid = 1'b1; evict_addr = la(i); evict_data = ld(i); evict_dirty = dirty;
        @(posedge clk); #1;
        evict_valid = 1'b0;
        chk(wb_valid == exp_wb, req, "wb_valid", LINE_W'(wb_valid), LINE_W'(exp_wb));
        if (exp_wb) begin
            chk(wb_addr == la(wb_i), req, "wb_addr", LINE_W'(wb_addr), LINE_W'(la(wb_i)));
            chk(wb_data == ld(wb_i), req, "wb_data", wb_data, ld(wb_i));
        end
    endtask

    // non-destructive probe: a hit is swapped back with itself
    task automatic peek(int i, bit exp_hit, bit exp_dirty, string req);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_addr = la(i);
        #1;
        chk(lkp_hit == exp_hit, req, "lkp_hit", LINE_W'(lkp_hit), LINE_W'(exp_hit));
        chk(fetch_req == !exp_hit, req, "fetch_req", LINE_W'(fetch_req), LINE_W'(!exp_hit));
        if (exp_hit) begin
            chk(lkp_data == ld(i), req, "lkp_data", lkp_data, ld(i));
            chk(lkp_dirty == exp_dirty, req, "lkp_dirty", LINE_W'(lkp_dirty), LINE_W'(exp_dirty));
        end else begin
            chk(fetch_addr == la(i), req, "fetch_addr", LINE_W'(fetch_addr), LINE_W'(la(i)));
        end
        if (lkp_hit) begin
            evict_valid = 1'b1; evict_addr = la(i); evict_data = lkp_data; evict_dirty = lkp_dirty;
        end
        @(posedge clk); #1;
        lkp_valid = 1'b0; evict_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", LINE_W'(wb_valid), '0);
        peek(0, 1'b0, 1'b0, "R1");
        peek(7, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_fill;
        evict(0, 1'b1, 1'b0, 0, "R6");
        evict(1, 1'b0, 1'b0, 0, "R6");
        evict(2, 1'b0, 1'b0, 0, "R6");
        evict(3, 1'b1, 1'b0, 0, "R6");
        for (int i = 0; i < 4; i++) peek(i, 1'b1, (i == 0 || i == 3), "R2");
    endtask

    task automatic t_rotate;
        evict(4, 1'b0, 1'b1, 0, "R8");   // pointer 0 holds modified line 0
        evict(5, 1'b0, 1'b0, 0, "R8");   // pointer 1 holds clean line 1
        peek(0, 1'b0, 1'b0, "R7");
        peek(1, 1'b0, 1'b0, "R7");
        peek(4, 1'b1, 1'b0, "R7");
        peek(5, 1'b1, 1'b0, "R7");
        peek(2, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_take_and_hole;
        @(negedge clk);
        lkp_valid = 1'b1; lkp_addr = la(2);
        #1;
        chk(lkp_hit == 1'b1, "R4", "consuming hit", LINE_W'(lkp_hit), 1);
        @(posedge clk); #1;
        lkp_valid = 1'b0;
        peek(2, 1'b0, 1'b0, "R4");
        evict(6, 1'b0, 1'b0, 0, "R6");    // fills the hole, pointer stays at 2
        peek(3, 1'b1, 1'b1, "R6");
        evict(7, 1'b0, 1'b0, 0, "R7");    // pointer 2 now holds clean line 6
        peek(6, 1'b0, 1'b0, "R7");
        peek(3, 1'b1, 1'b1, "R7");
        evict(8, 1'b0, 1'b1, 3, "R8");    // pointer 3 holds modified line 3
        peek(3, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_swap;
        @(negedge clk);
        lkp_valid = 1'b1; lkp_addr = la(4);
        evict_valid = 1'b1; evict_addr = la(9); evict_data = ld(9); evict_dirty = 1'b1;
        #1;
        chk(lkp_hit == 1'b1, "R5", "swap hit", LINE_W'(lkp_hit), 1);
        chk(lkp_data == ld(4), "R5", "swap data", lkp_data, ld(4));
        @(posedge clk); #1;
        lkp_valid = 1'b0; evict_valid = 1'b0;
        chk(wb_valid == 1'b0, "R5", "no writeback on swap", LINE_W'(wb_valid), '0);
        peek(4, 1'b0, 1'b0, "R5");
        peek(9, 1'b1, 1'b1, "R5");
        peek(5, 1'b1, 1'b0, "R5");
        // pointer wrapped to entry 0, which now holds modified line 9
        evict(10, 1'b0, 1'b1, 9, "R7");
        peek(9, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_idle;
        @(negedge clk);
        lkp_valid = 1'b0; lkp_addr = la(5);
        evict_valid = 1'b0; evict_addr = la(11); evict_data = ld(11); evict_dirty = 1'b1;
        #1;
        chk(lkp_hit == 1'b0, "R9", "hit while idle", LINE_W'(lkp_hit), '0);
        chk(fetch_req == 1'b0, "R9", "fetch while idle", LINE_W'(fetch_req), '0);
        @(posedge clk); #1;
        peek(11, 1'b0, 1'b0, "R9");
        peek(5, 1'b1, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_rotate();
        t_take_and_hole();
        t_swap();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule